// File: doc/BRIEF.md
# Microprogrammed Multicycle Control Sequencer

This block is the control unit for a multicycle processor datapath that uses a single memory for instructions and data. A microprogram counter selects one word of an internal microstore. Each word holds a 20-bit horizontal control vector and a small sequencing field. The control vector drives the datapath's multiplexers, load enables, memory strobes and ALU operation. The sequencing field chooses the next microaddress in one of four ways: step forward by one, return to fetch, dispatch through a decoder driven by the instruction's opcode and funct fields, or a conditional step qualified by the datapath's zero or carry flag.

Every instruction starts with a shared fetch step at microaddress 0 and a shared decode and dispatch step at microaddress 1. The decode step also computes the branch target into the Result register, so a taken branch only needs to load it into the PC. Register-type execution begins at microaddress 8. The control vector is registered, and it always reflects the word at the current microaddress. The datapath samples the vector during that cycle and returns its flags within the same cycle.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high reset forces the microaddress to 0. From the first clock edge with reset high, the control output equals the fetch word 0x54004 and stays there while reset is held. This holds even when reset arrives in the middle of an instruction.
- R2: Control bit assignment: 19 PC source (0 ALU, 1 Result), 18 PC load, 17 memory address source (0 PC, 1 Result), 16 memory read, 15 memory write, 14 IR load, 13 MDR load, 12 destination field (0 Rt, 1 Rd), 11 write-data source (0 Result, 1 MDR), 10 register write, 9 X load, 8 Y load, 7 ALU X source (0 PC, 1 X), 6:5 ALU Y source (00 constant 4, 01 Y, 10 sign-extended immediate, 11 immediate shifted left by 2), 4:1 ALU operation (0000 AND, 0001 OR, 0010 ADD, 0110 SUB, 0111 set-less-than), 0 Result load. The fetch word (microaddress 0) is 0x54004. Memory read and write are never asserted together.
- R3: Fetch is always followed by the decode word 0x00365 at microaddress 1. This word loads X and Y and computes Result = PC + (immediate << 2).
- R4: The decode step dispatches on the opcode and funct fields. Opcode 0x00 with funct 0x22 dispatches to 8 (SUB), 0x20 to 10 (ADD), 0x24 to 12 (AND), 0x25 to 14 (OR) and 0x2A to 20 (SLT). Opcode 0x04 dispatches to 16 (branch on zero), 0x05 to 18 (branch on carry), 0x0F to 24 (load immediate), 0x23 to 26 (load) and 0x2B to 29 (store).
- R5: A register-type instruction takes 4 cycles. Its execute word is 0x000A1 with the ALU code in bits 4:1. Its write-back word is 0x01400, which writes Result to the Rd register.
- R6: Load immediate takes 4 cycles. Its words are 0x000C5 (Result = X + immediate) and then 0x00400 (write Result to Rt).
- R7: Load takes 5 cycles. Its words are 0x000C5, then 0x32000 (read memory at Result into MDR), then 0x00C00 (write MDR to Rt).
- R8: Store takes 4 cycles. Its words are 0x000C5 and then 0x28000 (write Y to memory at Result).
- R9: A conditional branch issues the compare word 0x000AC (X - Y). The zero flag is selected for opcode 0x04 and the carry flag for 0x05. If the selected flag is 1, the next word is 0xC0000 (PC loaded from Result) and the instruction takes 4 cycles. Otherwise it returns to fetch after 3 cycles. The unselected flag has no effect.
- R10: An opcode, or a register-type funct, that has no entry point returns to fetch directly after decode (2 cycles).
- R11: The opcode and funct inputs have no effect outside the decode step. Changing them during the execute steps leaves the control sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| funct_i | input | 6 | Funct field of the instruction register |
| zero_i | input | 1 | ALU zero flag from the datapath |
| carry_i | input | 1 | ALU carry flag from the datapath |
| ctrl_o | output | 20 | Registered horizontal control vector |

## Verification
Two events can fall in the same cycle: a flag arriving at a conditional step, and the flag of the other kind that the step must ignore. The bench provokes this by sweeping both flags through all four combinations for every opcode. It expects a branch on zero to follow only the zero flag and a branch on carry to follow only the carry flag. A second case is reset arriving while an instruction is mid-flight. There the bench expects the fetch word at the next sample, in place of the step the instruction would otherwise have reached. In all cases the bench compares each sampled control word against words it assembles from the bit assignment.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int CW_W  = 20;
    localparam int UA_W  = 5;
    localparam int OP_W  = 6;
    localparam int FN_W  = 6;

    // control bit positions
    localparam int B_PCSRC = 19;
    localparam int B_PCLD  = 18;
    localparam int B_MADDR = 17;
    localparam int B_MRD   = 16;
    localparam int B_MWR   = 15;
    localparam int B_IRLD  = 14;
    localparam int B_MDRLD = 13;
    localparam int B_DST   = 12;
    localparam int B_WSRC  = 11;
    localparam int B_RWR   = 10;
    localparam int B_RLD   = 0;

    typedef enum logic [1:0] {
        YS_FOUR = 2'b00,
        YS_REG  = 2'b01,
        YS_IMM  = 2'b10,
        YS_IMM4 = 2'b11
    } ysrc_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_e;

    typedef enum logic [1:0] {
        SQ_INC   = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_MAP   = 2'd2,
        SQ_COND  = 2'd3
    } seq_e;

    typedef enum logic {
        CS_ZERO  = 1'b0,
        CS_CARRY = 1'b1
    } csel_e;

    // first member lands on bit 19
    typedef struct packed {
        logic  pc_src;
        logic  pc_ld;
        logic  maddr_src;
        logic  mem_rd;
        logic  mem_wr;
        logic  ir_ld;
        logic  mdr_ld;
        logic  dst_rd;
        logic  wsrc_mdr;
        logic  reg_wr;
        logic  x_ld;
        logic  y_ld;
        logic  x_src;
        ysrc_e y_src;
        alu_e  alu;
        logic  r_ld;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        seq_e  seq;
        csel_e csel;
    } uinst_t;

    typedef logic [UA_W-1:0] uaddr_t;

    // microstore layout
    localparam uaddr_t UA_FETCH  = UA_W'(0);
    localparam uaddr_t UA_DECODE = UA_W'(1);
    localparam uaddr_t UA_SUB    = UA_W'(8);
    localparam uaddr_t UA_ADD    = UA_W'(10);
    localparam uaddr_t UA_AND    = UA_W'(12);
    localparam uaddr_t UA_OR     = UA_W'(14);
    localparam uaddr_t UA_BEQ    = UA_W'(16);
    localparam uaddr_t UA_BCS    = UA_W'(18);
    localparam uaddr_t UA_SLT    = UA_W'(20);
    localparam uaddr_t UA_LI     = UA_W'(24);
    localparam uaddr_t UA_LW     = UA_W'(26);
    localparam uaddr_t UA_SW     = UA_W'(29);

    // instruction encodings
    localparam logic [OP_W-1:0] OPC_REG = 6'h00;
    localparam logic [OP_W-1:0] OPC_BEQ = 6'h04;
    localparam logic [OP_W-1:0] OPC_BCS = 6'h05;
    localparam logic [OP_W-1:0] OPC_LI  = 6'h0F;
    localparam logic [OP_W-1:0] OPC_LW  = 6'h23;
    localparam logic [OP_W-1:0] OPC_SW  = 6'h2B;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    // control word builders
    function automatic ctrl_t cw_fetch();
        ctrl_t c = '0;
        c.mem_rd = 1'b1;
        c.ir_ld  = 1'b1;
        c.pc_ld  = 1'b1;
        c.y_src  = YS_FOUR;
        c.alu    = ALU_ADD;
        return c;
    endfunction

    function automatic ctrl_t cw_decode();
        ctrl_t c = '0;
        c.x_ld  = 1'b1;
        c.y_ld  = 1'b1;
        c.y_src = YS_IMM4;
        c.alu   = ALU_ADD;
        c.r_ld  = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t cw_regop(alu_e op);
        ctrl_t c = '0;
        c.x_src = 1'b1;
        c.y_src = YS_REG;
        c.alu   = op;
        c.r_ld  = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t cw_compare();
        ctrl_t c = '0;
        c.x_src = 1'b1;
        c.y_src = YS_REG;
        c.alu   = ALU_SUB;
        return c;
    endfunction

    function automatic ctrl_t cw_jump();
        ctrl_t c = '0;
        c.pc_src = 1'b1;
        c.pc_ld  = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t cw_eaddr();
        ctrl_t c = '0;
        c.x_src = 1'b1;
        c.y_src = YS_IMM;
        c.alu   = ALU_ADD;
        c.r_ld  = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t cw_wb(logic to_rd, logic from_mdr);
        ctrl_t c = '0;
        c.dst_rd   = to_rd;
        c.wsrc_mdr = from_mdr;
        c.reg_wr   = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t cw_mem(logic wr);
        ctrl_t c = '0;
        c.maddr_src = 1'b1;
        c.mem_rd    = ~wr;
        c.mdr_ld    = ~wr;
        c.mem_wr    = wr;
        return c;
    endfunction

    function automatic uinst_t mk(ctrl_t c, seq_e s, csel_e cs);
        uinst_t u;
        u.ctrl = c;
        u.seq  = s;
        u.csel = cs;
        return u;
    endfunction

    // microprogram contents
    function automatic uinst_t ustore_word(uaddr_t a);
        uinst_t u;
        case (a)
            UA_FETCH:        u = mk(cw_fetch(),          SQ_INC,   CS_ZERO);
            UA_DECODE:       u = mk(cw_decode(),         SQ_MAP,   CS_ZERO);
            UA_SUB:          u = mk(cw_regop(ALU_SUB),   SQ_INC,   CS_ZERO);
            UA_ADD:          u = mk(cw_regop(ALU_ADD),   SQ_INC,   CS_ZERO);
            UA_AND:          u = mk(cw_regop(ALU_AND),   SQ_INC,   CS_ZERO);
            UA_OR:           u = mk(cw_regop(ALU_OR),    SQ_INC,   CS_ZERO);
            UA_SLT:          u = mk(cw_regop(ALU_SLT),   SQ_INC,   CS_ZERO);
            UA_SUB + 1'b1,
            UA_ADD + 1'b1,
            UA_AND + 1'b1,
            UA_OR  + 1'b1,
            UA_SLT + 1'b1:   u = mk(cw_wb(1'b1, 1'b0),   SQ_FETCH, CS_ZERO);
            UA_BEQ:          u = mk(cw_compare(),        SQ_COND,  CS_ZERO);
            UA_BCS:          u = mk(cw_compare(),        SQ_COND,  CS_CARRY);
            UA_BEQ + 1'b1,
            UA_BCS + 1'b1:   u = mk(cw_jump(),           SQ_FETCH, CS_ZERO);
            UA_LI,
            UA_LW,
            UA_SW:           u = mk(cw_eaddr(),          SQ_INC,   CS_ZERO);
            UA_LI + 1'b1:    u = mk(cw_wb(1'b0, 1'b0),   SQ_FETCH, CS_ZERO);
            UA_LW + 1'b1:    u = mk(cw_mem(1'b0),        SQ_INC,   CS_ZERO);
            UA_LW + 2'd2:    u = mk(cw_wb(1'b0, 1'b1),   SQ_FETCH, CS_ZERO);
            UA_SW + 1'b1:    u = mk(cw_mem(1'b1),        SQ_FETCH, CS_ZERO);
            default:         u = mk(ctrl_t'('0),         SQ_FETCH, CS_ZERO);
        endcase
        return u;
    endfunction

endpackage

// File: rtl/useq_map.sv
module useq_map
    import useq_pkg::*;
#(
    parameter int ADDR_W = UA_W,
    parameter int OPC_W  = OP_W,
    parameter int FUN_W  = FN_W
) (
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [FUN_W-1:0]  funct_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] entry_o
);

    logic [ADDR_W-1:0] reg_entry;
    logic              reg_hit;

    // register-type dispatch on funct
    always_comb begin
        reg_hit   = 1'b1;
        reg_entry = ADDR_W'(UA_FETCH);
        case (funct_i)
            FN_SUB:  reg_entry = ADDR_W'(UA_SUB);
            FN_ADD:  reg_entry = ADDR_W'(UA_ADD);
            FN_AND:  reg_entry = ADDR_W'(UA_AND);
            FN_OR:   reg_entry = ADDR_W'(UA_OR);
            FN_SLT:  reg_entry = ADDR_W'(UA_SLT);
            default: reg_hit   = 1'b0;
        endcase
    end

    // opcode dispatch
    always_comb begin
        hit_o   = 1'b1;
        entry_o = ADDR_W'(UA_FETCH);
        case (opcode_i)
            OPC_REG: begin
                hit_o   = reg_hit;
                entry_o = reg_entry;
            end
            OPC_BEQ: entry_o = ADDR_W'(UA_BEQ);
            OPC_BCS: entry_o = ADDR_W'(UA_BCS);
            OPC_LI:  entry_o = ADDR_W'(UA_LI);
            OPC_LW:  entry_o = ADDR_W'(UA_LW);
            OPC_SW:  entry_o = ADDR_W'(UA_SW);
            default: hit_o   = 1'b0;
        endcase
    end

endmodule

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int ADDR_W = UA_W
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    output uinst_t            rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    uinst_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = ustore_word(UA_W'(i));
    end

    assign rd_data_o = rom[rd_addr_i];

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int ADDR_W = UA_W
) (
    input  logic [ADDR_W-1:0] upc_i,
    input  seq_e              seq_i,
    input  csel_e             csel_i,
    input  logic              zero_i,
    input  logic              carry_i,
    input  logic              map_hit_i,
    input  logic [ADDR_W-1:0] map_entry_i,
    output logic [ADDR_W-1:0] upc_nxt_o
);

    logic              flag;
    logic [ADDR_W-1:0] upc_inc;

    assign flag    = (csel_i == CS_CARRY) ? carry_i : zero_i;
    assign upc_inc = upc_i + 1'b1;

    always_comb begin
        case (seq_i)
            SQ_INC:   upc_nxt_o = upc_inc;
            SQ_MAP:   upc_nxt_o = map_hit_i ? map_entry_i : '0;
            SQ_COND:  upc_nxt_o = flag ? upc_inc : '0;
            default:  upc_nxt_o = '0;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode_i,
    input  logic [FN_W-1:0] funct_i,
    input  logic            zero_i,
    input  logic            carry_i,
    output logic [CW_W-1:0] ctrl_o
);

    logic [UA_W-1:0] upc_q;
    logic [UA_W-1:0] upc_nxt;
    logic [UA_W-1:0] map_entry;
    logic            map_hit;
    uinst_t          uir_q;
    uinst_t          st_rdata;

    useq_map #(.ADDR_W(UA_W), .OPC_W(OP_W), .FUN_W(FN_W)) u_map (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .hit_o    (map_hit),
        .entry_o  (map_entry)
    );

    useq_next #(.ADDR_W(UA_W)) u_next (
        .upc_i       (upc_q),
        .seq_i       (uir_q.seq),
        .csel_i      (uir_q.csel),
        .zero_i      (zero_i),
        .carry_i     (carry_i),
        .map_hit_i   (map_hit),
        .map_entry_i (map_entry),
        .upc_nxt_o   (upc_nxt)
    );

    // read at the next address so the word register tracks the counter
    useq_store #(.ADDR_W(UA_W)) u_store (
        .rd_addr_i (upc_nxt),
        .rd_data_o (st_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upc_q <= UA_FETCH;
            uir_q <= ustore_word(UA_FETCH);
        end else begin
            upc_q <= upc_nxt;
            uir_q <= st_rdata;
        end
    end

    assign ctrl_o = uir_q.ctrl;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CW_W-1:0] ctrl_o,
    input  logic [UA_W-1:0] upc,
    input  logic            map_hit,
    input  logic [UA_W-1:0] map_entry,
    input  uinst_t          uir,
    input  logic            zero_i,
    input  logic            carry_i
);

    logic sel_flag;
    assign sel_flag = (uir.csel == CS_CARRY) ? carry_i : zero_i;

    p_reset_fetch_r1: assert property (@(posedge clk)
        rst |=> (upc == UA_FETCH) && (ctrl_o == CW_W'(ustore_word(UA_FETCH).ctrl)));

    p_rdwr_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_o[B_MRD] && ctrl_o[B_MWR]));

    p_fetch_decode_r3: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_FETCH) |=> (upc == UA_DECODE));

    p_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_DECODE) && map_hit |=> (upc == $past(map_entry)));

    p_regwr_source_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[B_RWR] |-> $past(ctrl_o[B_RLD] || ctrl_o[B_MDRLD]));

    p_cond_fail_r9: assert property (@(posedge clk) disable iff (rst)
        (uir.seq == SQ_COND) && !sel_flag |=> (upc == UA_FETCH));

    p_cond_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (uir.seq == SQ_COND) && sel_flag |=> (upc == $past(upc) + 1'b1));

    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_DECODE) && !map_hit |=> (upc == UA_FETCH));

endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_o    (ctrl_o),
    .upc       (upc_q),
    .map_hit   (map_hit),
    .map_entry (map_entry),
    .uir       (uir_q),
    .zero_i    (zero_i),
    .carry_i   (carry_i)
);

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
module test_useq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic        zero = 1'b0;
    logic        carry = 1'b0;
    logic [19:0] ctrl;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    useq_ctrl i_useq_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode_i (opcode),
        .funct_i  (funct),
        .zero_i   (zero),
        .carry_i  (carry),
        .ctrl_o   (ctrl)
    );

    // expected words assembled from the bit assignment (R2)
    function automatic logic [19:0] bit_at(int p);
        return 20'd1 << p;
    endfunction
    function automatic logic [19:0] ysel(int v);
        return 20'(v) << 5;
    endfunction
    function automatic logic [19:0] aluf(int v);
        return 20'(v) << 1;
    endfunction

    localparam int A_AND = 0, A_OR = 1, A_ADD = 2, A_SUB = 6, A_SLT = 7;

    logic [19:0] e_fetch, e_dec, e_rwb, e_cmp, e_jmp, e_ea, e_liw, e_lwm, e_lww, e_swm;
    initial begin
        e_fetch = bit_at(18) | bit_at(16) | bit_at(14) | ysel(0) | aluf(A_ADD);
        e_dec   = bit_at(9) | bit_at(8) | ysel(3) | aluf(A_ADD) | bit_at(0);
        e_rwb   = bit_at(12) | bit_at(10);
        e_cmp   = bit_at(7) | ysel(1) | aluf(A_SUB);
        e_jmp   = bit_at(19) | bit_at(18);
        e_ea    = bit_at(7) | ysel(2) | aluf(A_ADD) | bit_at(0);
        e_liw   = bit_at(10);
        e_lwm   = bit_at(17) | bit_at(16) | bit_at(13);
        e_lww   = bit_at(11) | bit_at(10);
        e_swm   = bit_at(17) | bit_at(15);
    end

    logic [19:0] exp_w [8];
    int          exp_n;
    string       exp_cls;

    task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] want);
        n_chk++;
        if (got !== want) begin
            n_err++;
            $display("FAIL %s: ctrl actual=%05h expected=%05h", tag, got, want);
        end
    endtask

    task automatic build(input logic [5:0] op, input logic [5:0] fn, input logic z, input logic c);
        int a;
        exp_w[0] = e_fetch;
        exp_w[1] = e_dec;
        exp_n = 2;
        exp_cls = "R10";
        if (op == 6'h00) begin
            a = -1;
            case (fn)
                6'h22: a = A_SUB;
                6'h20: a = A_ADD;
                6'h24: a = A_AND;
                6'h25: a = A_OR;
                6'h2A: a = A_SLT;
                default: a = -1;
            endcase
            if (a >= 0) begin
                exp_w[2] = bit_at(7) | ysel(1) | aluf(a) | bit_at(0);
                exp_w[3] = e_rwb;
                exp_n = 4;
                exp_cls = "R5";
            end
        end else if (op == 6'h04 || op == 6'h05) begin
            exp_w[2] = e_cmp;
            exp_cls = "R9";
            if ((op == 6'h04) ? z : c) begin
                exp_w[3] = e_jmp;
                exp_n = 4;
            end else begin
                exp_n = 3;
            end
        end else if (op == 6'h0F) begin
            exp_w[2] = e_ea; exp_w[3] = e_liw; exp_n = 4; exp_cls = "R6";
        end else if (op == 6'h23) begin
            exp_w[2] = e_ea; exp_w[3] = e_lwm; exp_w[4] = e_lww; exp_n = 5; exp_cls = "R7";
        end else if (op == 6'h2B) begin
            exp_w[2] = e_ea; exp_w[3] = e_swm; exp_n = 4; exp_cls = "R8";
        end
    endtask

    // starts and ends at a negedge with the fetch word showing
    task automatic run_instr(input logic [5:0] op, input logic [5:0] fn,
                             input logic z, input logic c, input bit scramble);
        string tag;
        build(op, fn, z, c);
        opcode = op;
        funct  = fn;
        zero   = z;
        carry  = c;
        for (int i = 0; i < exp_n; i++) begin
            if (i == 0)        tag = "R2";
            else if (i == 1)   tag = "R3";
            else if (scramble) tag = "R11";
            else if (i == 2)   tag = "R4";
            else               tag = exp_cls;
            chk(tag, ctrl, exp_w[i]);
            if (scramble && i >= 2) begin
                opcode = ~op;
                funct  = ~fn;
            end
            @(negedge clk);
        end
        chk(scramble ? "R11" : exp_cls, ctrl, e_fetch);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", ctrl, e_fetch);
        rst = 1'b0;

        // near-exhaustive sweep: all opcodes, all funct values, all flag pairs
        for (int op = 0; op < 64; op++) begin
            for (int zc = 0; zc < 4; zc++) begin
                if (op == 0) begin
                    for (int fn = 0; fn < 64; fn++)
                        run_instr(6'(op), 6'(fn), zc[1], zc[0], 1'b0);
                end else begin
                    run_instr(6'(op), 6'h3F, zc[1], zc[0], 1'b0);
                end
            end
        end

        // R11: fields changed after dispatch
        run_instr(6'h00, 6'h22, 1'b0, 1'b0, 1'b1);
        run_instr(6'h00, 6'h2A, 1'b1, 1'b1, 1'b1);
        run_instr(6'h04, 6'h00, 1'b1, 1'b0, 1'b1);
        run_instr(6'h05, 6'h00, 1'b0, 1'b1, 1'b1);
        run_instr(6'h0F, 6'h11, 1'b0, 1'b0, 1'b1);
        run_instr(6'h23, 6'h00, 1'b1, 1'b0, 1'b1);
        run_instr(6'h2B, 6'h07, 1'b0, 1'b1, 1'b1);

        // R1: reset in the middle of a load
        opcode = 6'h23; funct = 6'h00;
        repeat (3) @(negedge clk);
        chk("R7", ctrl, e_lwm);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", ctrl, e_fetch);
        @(negedge clk);
        chk("R1", ctrl, e_fetch);
        rst = 1'b0;
        run_instr(6'h00, 6'h20, 1'b0, 1'b0, 1'b0);

        report();
    end

endmodule